// File: doc/BRIEF.md
# Debounced 4x4 Keypad Scanner

This block reads a 16-key matrix that has four row drive lines and four active-low column sense lines. While idle it holds every row line low, so any pressed key pulls its column low. The column lines pass through a two-flop synchroniser first. Any change on them starts a debounce timer. Once the column pattern has held still long enough, the block notes which single column went low. It then releases the rows one at a time to find out which row carries the key.

The row and column positions are turned into a 4-bit key code through two fixed tables. That code is offered two ways: as a one-cycle valid pulse, and as a sticky ready level that can drive an interrupt line and is cleared by an acknowledge input. After each scan the rows go back to all-low. Detection re-arms only when every column has read released for a short guard time, so a key held down gives exactly one code.

Top module: `kpad_scan_top`

## Requirements
- R1: After reset `row_o` is 4'b0000, `key_valid_o` is 0 and `key_ready_o` is 0.
- R2: A scan starts only after the synchronised column pattern has been non-idle and unchanged for at least DEB_CYC clock cycles. A press shorter than that produces no code.
- R3: The column index comes from the one column found low at debounce time: `col_n_i[0]` low gives index 3, `col_n_i[1]` gives 1, `col_n_i[2]` gives 2, `col_n_i[3]` gives 0.
- R4: The scan drives `row_o` through 4'b0111, 4'b0011, 4'b0001 and 4'b0000, in that order (bit i drives row line i). It stops at the first step where the columns are not all ones.
- R5: The matching scan step sets a base value: step 0 gives 8, step 1 gives 0, step 2 gives 12, step 3 gives 4. `key_code_o` is that base plus the column index.
- R6: Each scan step holds its row pattern for SETTLE_CYC cycles before the columns are sampled.
- R7: In the cycle `key_valid_o` is high, `row_o` is back at 4'b0000.
- R8: `key_valid_o` is a one-cycle pulse. `key_ready_o` rises with it and stays high until `ack_i` is seen. `key_code_o` changes only together with a valid pulse.
- R9: A key held down yields a single code. A new code needs all columns to read released for SETTLE_CYC cycles and then a fresh debounced press.
- R10: If more than one column is low when debounce completes, no code is produced.
- R11: If no scan step finds a low column, no code is produced and the rows return to 4'b0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| col_n_i | input | 4 | Column sense lines, low when a key on a driven-low row is pressed |
| ack_i | input | 1 | Clears the sticky ready flag |
| row_o | output | 4 | Row drive lines |
| key_code_o | output | 4 | Last key code |
| key_valid_o | output | 1 | One-cycle pulse when a new code is produced |
| key_ready_o | output | 1 | Sticky new-code flag, usable as an interrupt request |

## Verification
Each of the sixteen keys is pressed alone. This separates every row-step and column-index pair in the code tables, so a swapped table entry or a wrong step order shows up as a wrong code. A key on the last-scanned row is used to watch the full row release sequence and how long each step lasts. A glitch shorter than the debounce window and a measured press-to-code latency bound the debounce from both sides. Holding a key, pressing two columns at once and letting go of a key in the middle of a scan each check a different path that must give no code. Acknowledge handling is checked separately.

// File: rtl/kpad_pkg.sv
package kpad_pkg;
  localparam int KP_LINES  = 4;
  localparam int KP_CODE_W = 4;

  typedef enum logic [1:0] {SC_IDLE, SC_SCAN, SC_REL} scan_st_t;

  // one-hot column event to column index
  function automatic logic [1:0] col_to_idx(input logic [KP_LINES-1:0] ev);
    logic [1:0] idx;
    case (ev)
      4'b0001: idx = 2'd3;
      4'b0010: idx = 2'd1;
      4'b0100: idx = 2'd2;
      default: idx = 2'd0;
    endcase
    return idx;
  endfunction

  // base code for each scan step
  function automatic logic [KP_CODE_W-1:0] step_base(input logic [1:0] s);
    logic [KP_CODE_W-1:0] b;
    case (s)
      2'd0:    b = 4'd8;
      2'd1:    b = 4'd0;
      2'd2:    b = 4'd12;
      default: b = 4'd4;
    endcase
    return b;
  endfunction

  // progressive row release pattern for each step
  function automatic logic [KP_LINES-1:0] step_rows(input logic [1:0] s);
    return 4'b0111 >> s;
  endfunction
endpackage

// File: rtl/kpad_sync.sv
module kpad_sync #(
  parameter int              W       = 4,
  parameter logic [W-1:0]    RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/kpad_debounce.sv
module kpad_debounce #(
  parameter int W       = 4,
  parameter int DEB_CYC = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] col_i,
  output logic         evt_o,
  output logic [W-1:0] evt_cols_o
);
  localparam int            CW  = $clog2(DEB_CYC + 1);
  localparam logic [CW-1:0] TOP = CW'(DEB_CYC);
  localparam logic [CW-1:0] HIT = CW'(DEB_CYC - 1);

  logic [W-1:0]  last_q, last_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          evt_q, evt_n;
  logic [W-1:0]  cols_q, cols_n;

  always_comb begin
    last_n = last_q;
    cnt_n  = cnt_q;
    evt_n  = 1'b0;
    cols_n = cols_q;
    if (!en_i) begin
      last_n = '1;
      cnt_n  = '0;
    end else if (col_i != last_q) begin
      last_n = col_i;
      cnt_n  = '0;
    end else if (col_i != '1) begin
      if (cnt_q != TOP) cnt_n = cnt_q + CW'(1);
      if (cnt_q == HIT) begin
        evt_n  = 1'b1;
        cols_n = ~col_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '1;
      cnt_q  <= '0;
      evt_q  <= 1'b0;
      cols_q <= '0;
    end else begin
      last_q <= last_n;
      cnt_q  <= cnt_n;
      evt_q  <= evt_n;
      cols_q <= cols_n;
    end
  end

  assign evt_o      = evt_q;
  assign evt_cols_o = cols_q;

  // R2: an accepted event fires once and always names at least one column
  p_evt_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |=> !evt_q);
  p_evt_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |-> (cols_q != '0));
endmodule

// File: rtl/kpad_scan.sv
module kpad_scan
  import kpad_pkg::*;
#(
  parameter int SETTLE_CYC = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 evt_i,
  input  logic [KP_LINES-1:0]  evt_cols_i,
  input  logic [KP_LINES-1:0]  col_i,
  output logic                 arm_o,
  output logic [KP_LINES-1:0]  rows_o,
  output logic [KP_CODE_W-1:0] code_o,
  output logic                 valid_o
);
  localparam int            TW    = $clog2(SETTLE_CYC + 1);
  localparam logic [TW-1:0] TLAST = TW'(SETTLE_CYC - 1);

  scan_st_t             st_q, st_n;
  logic [1:0]           step_q, step_n;
  logic [TW-1:0]        tmr_q, tmr_n;
  logic [1:0]           cidx_q, cidx_n;
  logic [KP_LINES-1:0]  rows_q, rows_n;
  logic [KP_CODE_W-1:0] code_q, code_n;
  logic                 valid_q, valid_n;

  always_comb begin
    st_n    = st_q;
    step_n  = step_q;
    tmr_n   = tmr_q;
    cidx_n  = cidx_q;
    rows_n  = rows_q;
    code_n  = code_q;
    valid_n = 1'b0;
    case (st_q)
      SC_IDLE: begin
        rows_n = '0;
        if (evt_i) begin
          tmr_n = '0;
          if ($onehot(evt_cols_i)) begin
            cidx_n = col_to_idx(evt_cols_i);
            step_n = 2'd0;
            rows_n = step_rows(2'd0);
            st_n   = SC_SCAN;
          end else begin
            st_n = SC_REL;
          end
        end
      end
      SC_SCAN: begin
        if (tmr_q != TLAST) begin
          tmr_n = tmr_q + TW'(1);
        end else begin
          tmr_n = '0;
          if (col_i != '1) begin
            code_n  = step_base(step_q) + {2'b00, cidx_q};
            valid_n = 1'b1;
            rows_n  = '0;
            st_n    = SC_REL;
          end else if (step_q == 2'd3) begin
            rows_n = '0;
            st_n   = SC_REL;
          end else begin
            step_n = step_q + 2'd1;
            rows_n = step_rows(step_q + 2'd1);
          end
        end
      end
      SC_REL: begin
        rows_n = '0;
        if (col_i != '1) begin
          tmr_n = '0;
        end else if (tmr_q != TLAST) begin
          tmr_n = tmr_q + TW'(1);
        end else begin
          tmr_n = '0;
          st_n  = SC_IDLE;
        end
      end
      default: st_n = SC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SC_IDLE;
      step_q  <= 2'd0;
      tmr_q   <= '0;
      cidx_q  <= 2'd0;
      rows_q  <= '0;
      code_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      step_q  <= step_n;
      tmr_q   <= tmr_n;
      cidx_q  <= cidx_n;
      rows_q  <= rows_n;
      code_q  <= code_n;
      valid_q <= valid_n;
    end
  end

  assign arm_o   = (st_q == SC_IDLE);
  assign rows_o  = rows_q;
  assign code_o  = code_q;
  assign valid_o = valid_q;

  // R4: rows only ever show one of the four release patterns
  p_rows_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (((rows_q & (rows_q + 4'd1)) == 4'd0) && !rows_q[3]));
  // R6: a step's pattern is not changed before its settle time ends
  p_step_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SC_SCAN && tmr_q != TLAST) |=> $stable(rows_q));
  // R7: rows are back low whenever a code is issued
  p_valid_rows_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (rows_q == '0));
  // R1: while armed the rows are held low
  p_armed_rows_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_o && !$past(arm_o)) |-> (rows_q == '0));
endmodule

// File: rtl/kpad_scan_top.sv
module kpad_scan_top
  import kpad_pkg::*;
#(
  parameter int DEB_CYC    = 15_000_000,
  parameter int SETTLE_CYC = 1250
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [KP_LINES-1:0]  col_n_i,
  input  logic                 ack_i,
  output logic [KP_LINES-1:0]  row_o,
  output logic [KP_CODE_W-1:0] key_code_o,
  output logic                 key_valid_o,
  output logic                 key_ready_o
);
  logic [1:0]          rsync_q;
  logic                rst_n_s;
  logic [KP_LINES-1:0] col_s;
  logic                evt;
  logic [KP_LINES-1:0] evt_cols;
  logic                arm;
  logic                ready_q, ready_n;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_s = rsync_q[1];

  kpad_sync #(.W(KP_LINES), .RST_VAL('1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d_i   (col_n_i),
    .q_o   (col_s)
  );

  kpad_debounce #(.W(KP_LINES), .DEB_CYC(DEB_CYC)) u_deb (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .en_i       (arm),
    .col_i      (col_s),
    .evt_o      (evt),
    .evt_cols_o (evt_cols)
  );

  kpad_scan #(.SETTLE_CYC(SETTLE_CYC)) u_scan (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .evt_i      (evt),
    .evt_cols_i (evt_cols),
    .col_i      (col_s),
    .arm_o      (arm),
    .rows_o     (row_o),
    .code_o     (key_code_o),
    .valid_o    (key_valid_o)
  );

  always_comb begin
    ready_n = ready_q;
    if (key_valid_o)  ready_n = 1'b1;
    else if (ack_i)   ready_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) ready_q <= 1'b0;
    else          ready_q <= ready_n;
  end

  assign key_ready_o = ready_q;

  // R8: pulse width, flag set, flag hold and code hold
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    key_valid_o |=> !key_valid_o);
  p_ready_set_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    key_valid_o |=> key_ready_o);
  p_ready_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (key_ready_o && !ack_i) |=> key_ready_o);
  p_code_hold_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    !key_valid_o |-> $stable(key_code_o));
endmodule

// File: tb/kpad_scan_top_tb_top.sv
module kpad_scan_top_tb_top;
  localparam int DEB = 20;
  localparam int SET = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] col_n;
  logic       ack;
  logic [3:0] row_o;
  logic [3:0] key_code;
  logic       key_valid;
  logic       key_ready;
  logic [15:0] keys;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  kpad_scan_top #(.DEB_CYC(DEB), .SETTLE_CYC(SET)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .col_n_i     (col_n),
    .ack_i       (ack),
    .row_o       (row_o),
    .key_code_o  (key_code),
    .key_valid_o (key_valid),
    .key_ready_o (key_ready)
  );

  // key matrix: key (r,c) pulls column c low while row line r is low
  always_comb begin
    col_n = 4'hF;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        if (keys[r*4+c] && !row_o[r]) col_n[c] = 1'b0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_code(input int r, input int c);
    int base, idx;
    case (r) 3: base = 8; 2: base = 0; 1: base = 12; default: base = 4; endcase
    case (c) 0: idx = 3; 1: idx = 1; 2: idx = 2; default: idx = 0; endcase
    return base + idx;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_valid(input int maxc, output bit seen, output int cyc);
    seen = 0; cyc = 0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      cyc++;
      if (key_valid) begin seen = 1; break; end
    end
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic t_reset();
    chk(row_o == 4'h0, "R1 rows", row_o, 0);
    chk(!key_valid, "R1 valid", key_valid, 0);
    chk(!key_ready, "R1 ready", key_ready, 0);
  endtask

  task automatic t_all_keys();
    bit seen; int cyc;
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < 4; c++) begin
        keys = 16'(1) << (r*4+c);
        wait_valid(300, seen, cyc);
        chk(seen, "R5 code produced", seen, 1);
        chk(key_code == 4'(exp_code(r, c)), "R3 R5 code value", key_code, exp_code(r, c));
        @(negedge clk);
        chk(!key_valid, "R8 pulse width", key_valid, 0);
        keys = '0;
        idle(30);
        do_ack();
      end
    end
  endtask

  task automatic t_latency();
    bit seen; int cyc;
    keys = 16'(1) << 9;
    wait_valid(300, seen, cyc);
    chk(seen && cyc >= DEB, "R2 debounce latency", cyc, DEB);
    keys = '0; idle(30); do_ack();
  endtask

  task automatic t_glitch();
    bit seen; int cyc;
    keys = 16'(1) << 5;
    idle(DEB/2);
    keys = '0;
    wait_valid(120, seen, cyc);
    chk(!seen, "R2 short press ignored", seen, 0);
    chk(row_o == 4'h0, "R2 rows idle after glitch", row_o, 0);
  endtask

  task automatic t_sequence();
    logic [3:0] seq [8];
    int dur [8];
    int n = 0;
    logic [3:0] prev = 4'h0;
    bit seen = 0;
    keys = 16'(1) << 2;  // row 0, column 2: found at the last step
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (row_o != prev && n < 8) begin
        seq[n] = row_o; dur[n] = 0; n++;
        prev = row_o;
      end else if (n > 0 && n <= 8) begin
        dur[n-1]++;
      end
      if (key_valid) begin seen = 1; break; end
    end
    chk(seen, "R4 scan completes", seen, 1);
    chk(n == 4, "R4 step count", n, 4);
    chk(seq[0] == 4'b0111, "R4 step0 rows", seq[0], 7);
    chk(seq[1] == 4'b0011, "R4 step1 rows", seq[1], 3);
    chk(seq[2] == 4'b0001, "R4 step2 rows", seq[2], 1);
    chk(seq[3] == 4'b0000, "R4 step3 rows", seq[3], 0);
    for (int k = 0; k < 3; k++)
      chk(dur[k] + 1 >= SET, "R6 settle length", dur[k] + 1, SET);
    chk(row_o == 4'h0, "R7 rows low with valid", row_o, 0);
    chk(key_code == 4'd6, "R5 last-step code", key_code, 6);
  endtask

  task automatic t_ack();
    logic [3:0] held;
    held = key_code;
    idle(10);
    chk(key_ready, "R8 ready sticky", key_ready, 1);
    do_ack();
    chk(!key_ready, "R8 ready cleared by ack", key_ready, 0);
    chk(key_code == held, "R8 code held", key_code, held);
  endtask

  task automatic t_hold_rearm();
    bit seen; int cyc;
    // key from t_sequence still held
    wait_valid(150, seen, cyc);
    chk(!seen, "R9 held key one code", seen, 0);
    keys = '0;
    idle(30);
    keys = 16'(1) << 2;
    wait_valid(300, seen, cyc);
    chk(seen, "R9 re-armed after release", seen, 1);
    keys = '0; idle(30); do_ack();
  endtask

  task automatic t_multi();
    bit seen; int cyc;
    keys = (16'(1) << 4) | (16'(1) << 7);  // row 1, columns 0 and 3
    wait_valid(150, seen, cyc);
    chk(!seen, "R10 two columns no code", seen, 0);
    keys = '0; idle(30);
  endtask

  task automatic t_lost();
    bit seen; int cyc;
    bit hit = 0;
    keys = 16'(1) << 1;  // row 0, column 1
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (row_o == 4'b0111) begin hit = 1; break; end
    end
    keys = '0;
    chk(hit, "R11 scan started", hit, 1);
    wait_valid(150, seen, cyc);
    chk(!seen, "R11 no match no code", seen, 0);
    chk(row_o == 4'h0, "R11 rows idle", row_o, 0);
    chk(!key_ready, "R11 ready stays low", key_ready, 0);
  endtask

  initial begin
    rst_n = 1'b0; ack = 1'b0; keys = '0;
    idle(5);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_all_keys();
    t_latency();
    t_glitch();
    t_sequence();
    t_ack();
    t_hold_rearm();
    t_multi();
    t_lost();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule